// File: doc/BRIEF.md
# Output Fault Protection Sequencer

This block sits beside one regulated output and decides, cycle by cycle, whether that output may be driven. Two comparators feed it. One reports overload and the other reports reverse (back) current. The block turns their levels into an output-enable, a current-limit-active indication and two sticky or following status flags. All timing is counted in ticks of a one-microsecond enable strobe, and every interval is a parameter, so a simulation can use short windows.

There are two overload policies, chosen by a mode input. In hiccup (dynamic) mode, a qualified overload switches the output off for a long cool-down. The output then returns under current limit for a short trial window. The overload flag drops only when a whole trial window passes without any overload. In static mode the output is never switched off for overload, and the flag simply follows the comparator. A separate loop handles back current with its own qualification span and off span, and it keeps cycling until the reverse current goes away.

Top module: `ofp_chan_guard`

## Requirements
- R1: After synchronous reset, both flags and `ilim_active` are low and the output is enabled exactly when `chan_en` is high.
- R2: In dynamic mode (`static_mode` = 0), an overload held for `OVL_QUAL_US` consecutive ticks turns `out_en` off at the clock edge of the last qualifying tick. `ovl_flag` rises at that same edge.
- R3: The overload off span lasts `OVL_OFF_US` ticks. Then the output comes back with `ilim_active` high for a trial window of `OVL_ON_US` ticks.
- R4: During the trial window, a qualified overload returns the block to the off span at once. If the comparator was high in any cycle of the window without qualifying, the block returns to the off span when the window ends.
- R5: At the end of a trial window with no overload, the block returns to normal operation, `ovl_flag` goes low and `ilim_active` goes low.
- R6: In static mode, overload never switches the output off. `ovl_flag` equals the comparator value one clock later, and `ilim_active` is high while the comparator and `chan_en` are both high.
- R7: Back current held for `BKC_QUAL_US` consecutive ticks turns the output off for `BKC_OFF_US` ticks and sets `bkc_flag` at the edge that switches the output off.
- R8: After the back-current off span, the output runs again and needs a fresh qualification. `bkc_flag` clears at the first clock where the loop is running and the back-current comparator is low.
- R9: While `chan_en` is low, the output is off and both loops return to their running state with cleared timers. `ovl_flag` holds its value in dynamic mode, and `bkc_flag` changes only by its R8 rule.
- R10: When the mode changes from static to dynamic while overload is present, the qualification count starts from zero.
- R11: `out_en` is high only when `chan_en` is high and neither loop is in its off span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| chan_en | input | 1 | Channel enable from control |
| static_mode | input | 1 | 1 = static overload policy, 0 = hiccup policy |
| ovl_cmp | input | 1 | Synchronous overload comparator |
| bkc_cmp | input | 1 | Synchronous back-current comparator |
| out_en | output | 1 | Output drive enable |
| ilim_active | output | 1 | Output is running under current limit |
| ovl_flag | output | 1 | Overload status flag |
| bkc_flag | output | 1 | Back-current status flag |

## Verification
A wrong phase in the overload loop shows on `out_en` within one clock of the expected edge. A trial window that is counted too short or too long moves the fall of `ovl_flag` or the next off span by whole ticks, which is three clocks in the bench. A qualification counter that is not cleared on a mode change or a disable shows as an early shutdown before the full qualification span has passed. The reference model compares all four outputs every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/ofp_pkg.sv
`timescale 1ns/1ps
// Shared phase encodings for the output fault protection sequencer.
package ofp_pkg;
    // Overload loop phases: normal running, cool-down off, current-limited trial.
    typedef enum logic [1:0] {
        OV_RUN = 2'd0,
        OV_OFF = 2'd1,
        OV_WIN = 2'd2
    } ovl_st_e;

    // Back-current loop phases: running, forced off.
    typedef enum logic {
        BK_RUN = 1'b0,
        BK_OFF = 1'b1
    } bkc_st_e;
endpackage

// File: rtl/ofp_span_timer.sv
`timescale 1ns/1ps
// Counts microsecond ticks while 'run' is held. It flags the tick that
// completes LEN ticks. Assumes LEN >= 1. Dropping 'run' clears the count
// at the next edge.
module ofp_span_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic last
);
    localparam int unsigned W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] FINAL = W'(LEN - 1);

    logic [W-1:0] cnt;

    assign last = run & tick & (cnt == FINAL);

    // Advance on ticks while running, wrap on completion, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ofp_ovl_ctrl.sv
`timescale 1ns/1ps
// Overload policy loop. In hiccup mode it qualifies the overload, holds a
// cool-down off span and then a current-limited trial window. In static
// mode it only mirrors the comparator into the flag. Assumes the comparator
// is already synchronous to clk.
module ofp_ovl_ctrl
    import ofp_pkg::*;
#(
    parameter int unsigned QUAL_US = 23,
    parameter int unsigned OFF_US  = 900000,
    parameter int unsigned ON_US   = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic chan_en,
    input  logic static_mode,
    input  logic ovl_cmp,
    output logic shut,
    output logic limiting,
    output logic flag
);
    ovl_st_e st, nxt;
    logic    qual_last, off_last, win_last;
    logic    seen, trip, clean_end, dyn_act;

    assign dyn_act = chan_en & ~static_mode;

    ofp_span_timer #(.LEN(QUAL_US)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(dyn_act & ovl_cmp & (st != OV_OFF)), .last(qual_last));

    ofp_span_timer #(.LEN(OFF_US)) u_off (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(dyn_act & (st == OV_OFF)), .last(off_last));

    ofp_span_timer #(.LEN(ON_US)) u_win (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(dyn_act & (st == OV_WIN)), .last(win_last));

    assign clean_end = (st == OV_WIN) & ~qual_last & win_last & ~(seen | ovl_cmp);

    // Next phase of the hiccup sequence.
    always_comb begin
        nxt = st;
        if (!dyn_act) begin
            nxt = OV_RUN;
        end else begin
            case (st)
                OV_RUN: if (qual_last) nxt = OV_OFF;
                OV_OFF: if (off_last)  nxt = OV_WIN;
                OV_WIN: begin
                    if (qual_last)      nxt = OV_OFF;
                    else if (win_last)  nxt = (seen | ovl_cmp) ? OV_OFF : OV_RUN;
                end
                default: nxt = OV_RUN;
            endcase
        end
    end

    assign trip = (nxt == OV_OFF) & (st != OV_OFF);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= OV_RUN;
        else        st <= nxt;
    end

    // Remembers any overload seen inside the current trial window.
    always_ff @(posedge clk) begin
        if (!rst_n || st != OV_WIN) seen <= 1'b0;
        else                        seen <= seen | ovl_cmp;
    end

    // Flag: follows the comparator in static mode, set/clear rules in hiccup mode.
    always_ff @(posedge clk) begin
        if (!rst_n)               flag <= 1'b0;
        else if (static_mode)     flag <= ovl_cmp;
        else if (!chan_en)        flag <= flag;
        else if (trip)            flag <= 1'b1;
        else if (clean_end)       flag <= 1'b0;
    end

    assign shut     = (st == OV_OFF);
    assign limiting = chan_en & ((st == OV_WIN) | (static_mode & ovl_cmp));

    // R2: the off span is always flagged.
    a_r2_off_is_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OV_OFF) |-> flag);

    // R6: static mode never leads to the off span.
    a_r6_static_never_off: assert property (@(posedge clk) disable iff (!rst_n)
        static_mode |=> (st != OV_OFF));

    // R9: a disabled channel returns the loop to running.
    a_r9_disable_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (st == OV_RUN));

    // R5: in hiccup mode the flag only falls out of a trial window.
    a_r5_flag_falls_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_mode && $past(!static_mode) && $fell(flag)) |-> $past(st == OV_WIN));
endmodule

// File: rtl/ofp_bkc_ctrl.sv
`timescale 1ns/1ps
// Back-current retry loop. A back current that stays present for the
// qualification span forces an off span, and the loop then retries. Assumes
// the comparator is synchronous to clk.
module ofp_bkc_ctrl
    import ofp_pkg::*;
#(
    parameter int unsigned QUAL_US = 100,
    parameter int unsigned OFF_US  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic chan_en,
    input  logic bkc_cmp,
    output logic shut,
    output logic flag
);
    bkc_st_e st, nxt;
    logic    qual_last, off_last;

    ofp_span_timer #(.LEN(QUAL_US)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(chan_en & bkc_cmp & (st == BK_RUN)), .last(qual_last));

    ofp_span_timer #(.LEN(OFF_US)) u_off (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(chan_en & (st == BK_OFF)), .last(off_last));

    // Next phase of the retry loop.
    always_comb begin
        nxt = st;
        if (!chan_en)                         nxt = BK_RUN;
        else if (st == BK_RUN && qual_last)   nxt = BK_OFF;
        else if (st == BK_OFF && off_last)    nxt = BK_RUN;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BK_RUN;
        else        st <= nxt;
    end

    // Flag: set on entry to the off span, cleared once running with no back current.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag <= 1'b0;
        else if (nxt == BK_OFF && st == BK_RUN)    flag <= 1'b1;
        else if (st == BK_RUN && !bkc_cmp)         flag <= 1'b0;
    end

    assign shut = (st == BK_OFF);

    // R7: the off span is always flagged.
    a_r7_off_is_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_OFF) |-> flag);

    // R8: the flag only falls after running with the comparator low.
    a_r8_flag_clear_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(st == BK_RUN && !bkc_cmp));
endmodule

// File: rtl/ofp_chan_guard.sv
`timescale 1ns/1ps
// Per-channel fault protection top. It combines the overload policy loop and
// the back-current retry loop into one output-enable and the status outputs.
// Assumes tick_us is a one-cycle strobe and that all inputs are synchronous.
module ofp_chan_guard #(
    parameter int unsigned OVL_QUAL_US = 23,
    parameter int unsigned OVL_OFF_US  = 900000,
    parameter int unsigned OVL_ON_US   = 20000,
    parameter int unsigned BKC_QUAL_US = 100,
    parameter int unsigned BKC_OFF_US  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic chan_en,
    input  logic static_mode,
    input  logic ovl_cmp,
    input  logic bkc_cmp,
    output logic out_en,
    output logic ilim_active,
    output logic ovl_flag,
    output logic bkc_flag
);
    logic ovl_shut, bkc_shut;

    ofp_ovl_ctrl #(
        .QUAL_US(OVL_QUAL_US), .OFF_US(OVL_OFF_US), .ON_US(OVL_ON_US)
    ) u_ovl (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .chan_en(chan_en),
        .static_mode(static_mode), .ovl_cmp(ovl_cmp),
        .shut(ovl_shut), .limiting(ilim_active), .flag(ovl_flag));

    ofp_bkc_ctrl #(
        .QUAL_US(BKC_QUAL_US), .OFF_US(BKC_OFF_US)
    ) u_bkc (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .chan_en(chan_en),
        .bkc_cmp(bkc_cmp), .shut(bkc_shut), .flag(bkc_flag));

    // R11: drive only when enabled and neither loop holds the output off.
    assign out_en = chan_en & ~ovl_shut & ~bkc_shut;
endmodule

// File: tb/sim_ofp_chan_guard.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is compared on every clock, and
// directed checks are added at the points the requirements name.
module sim_ofp_chan_guard;
    localparam int QO = 4, FO = 20, NO = 10, QB = 5, FB = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, tick_us = 1'b0, chan_en = 1'b0, static_mode = 1'b0;
    logic ovl_cmp = 1'b0, bkc_cmp = 1'b0;
    logic out_en, ilim_active, ovl_flag, bkc_flag;

    ofp_chan_guard #(
        .OVL_QUAL_US(QO), .OVL_OFF_US(FO), .OVL_ON_US(NO),
        .BKC_QUAL_US(QB), .BKC_OFF_US(FB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .chan_en(chan_en),
        .static_mode(static_mode), .ovl_cmp(ovl_cmp), .bkc_cmp(bkc_cmp),
        .out_en(out_en), .ilim_active(ilim_active),
        .ovl_flag(ovl_flag), .bkc_flag(bkc_flag));

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0, armed = 0;

    // Tick strobe: one cycle in three.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick_us <= (tdiv == 0);
    end

    // Reference model state (phase: 0 run, 1 off, 2 trial window).
    int m_ov = 0, m_oq = 0, m_ot = 0, m_bk = 0, m_bq = 0, m_bt = 0;
    bit m_seen = 0, m_of = 0, m_bf = 0, trp;

    task automatic ov_go_off();
        m_ov = 1; m_oq = 0; m_ot = 0; m_seen = 0; m_of = 1;
    endtask

    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            m_ov = 0; m_oq = 0; m_ot = 0; m_seen = 0; m_of = 0;
            m_bk = 0; m_bq = 0; m_bt = 0; m_bf = 0;
        end else begin
            // overload loop
            if (!chan_en || static_mode) begin
                if (static_mode) m_of = ovl_cmp;
                m_ov = 0; m_oq = 0; m_ot = 0; m_seen = 0;
            end else if (m_ov == 0) begin
                if (ovl_cmp) begin
                    if (tick_us) m_oq++;
                    if (m_oq == QO) ov_go_off();
                end else m_oq = 0;
            end else if (m_ov == 1) begin
                if (tick_us) m_ot++;
                if (m_ot == FO) begin m_ov = 2; m_ot = 0; end
            end else begin
                trp = 0;
                if (ovl_cmp) begin
                    if (tick_us) m_oq++;
                    if (m_oq == QO) trp = 1;
                end else m_oq = 0;
                m_seen = m_seen | ovl_cmp;
                if (tick_us) m_ot++;
                if (trp) ov_go_off();
                else if (m_ot == NO) begin
                    if (m_seen) ov_go_off();
                    else begin m_ov = 0; m_of = 0; m_ot = 0; m_seen = 0; m_oq = 0; end
                end
            end
            // back-current loop
            if (m_bk == 0 && !bkc_cmp) m_bf = 0;
            if (!chan_en) begin
                m_bk = 0; m_bq = 0; m_bt = 0;
            end else if (m_bk == 0) begin
                if (bkc_cmp) begin
                    if (tick_us) m_bq++;
                    if (m_bq == QB) begin m_bk = 1; m_bq = 0; m_bt = 0; m_bf = 1; end
                end else m_bq = 0;
            end else begin
                if (tick_us) m_bt++;
                if (m_bt == FB) begin m_bk = 0; m_bt = 0; end
            end
        end
    end

    // Every-clock comparison of all four outputs (R11 for out_en composition).
    always @(negedge clk) begin
        #3;
        if (armed && !done) begin
            logic [3:0] expv, actv;
            expv = {chan_en && m_ov != 1 && m_bk != 1,
                    chan_en && (m_ov == 2 || (static_mode && ovl_cmp)),
                    m_of, m_bf};
            actv = {out_en, ilim_active, ovl_flag, bkc_flag};
            n_chk++;
            if (actv !== expv) begin
                n_fail++;
                $display("FAIL %s/R11 model {out,ilim,oflag,bflag} actual=%b expected=%b at %0t",
                         cur_req, actv, expv, $time);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #4;
    endtask

    task automatic wait_out(input logic v, input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk); #4;
            if (out_en === v) break;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        cyc(4);
        chk("R1 out_en in reset", out_en, 1'b0);
        rst_n = 1'b1; cyc(2);
        chk("R1 ovl_flag", ovl_flag, 1'b0);
        chk("R1 bkc_flag", bkc_flag, 1'b0);
        chk("R1 ilim", ilim_active, 1'b0);
        chan_en = 1'b1; cyc(1);
        chk("R1 out_en follows enable", out_en, 1'b1);

        // R2/R3/R4: persistent overload in hiccup mode
        cur_req = "R2"; ovl_cmp = 1'b1;
        cyc(3 * QO - 3);
        chk("R2 no trip before qualification", out_en, 1'b1);
        wait_out(1'b0, 50);
        chk("R2 shut", out_en, 1'b0);
        chk("R2 flag set with shutdown", ovl_flag, 1'b1);
        cur_req = "R3"; wait_out(1'b1, 3 * FO + 10);
        chk("R3 trial window limiting", ilim_active, 1'b1);
        cur_req = "R4"; wait_out(1'b0, 3 * QO + 10);
        chk("R4 qualified in window re-shuts", out_en, 1'b0);

        // R5: clean window
        cur_req = "R5"; ovl_cmp = 1'b0;
        wait_out(1'b1, 3 * FO + 10);
        cyc(3 * NO + 6);
        chk("R5 flag cleared", ovl_flag, 1'b0);
        chk("R5 ilim cleared", ilim_active, 1'b0);
        chk("R5 output on", out_en, 1'b1);

        // R4: unqualified blip in window
        cur_req = "R4"; ovl_cmp = 1'b1;
        wait_out(1'b0, 50); ovl_cmp = 1'b0;
        wait_out(1'b1, 3 * FO + 10);
        cyc(3); ovl_cmp = 1'b1; cyc(1); ovl_cmp = 1'b0;
        wait_out(1'b0, 3 * NO + 10);
        chk("R4 blip sends back to off", out_en, 1'b0);
        chk("R4 flag still set", ovl_flag, 1'b1);
        wait_out(1'b1, 3 * FO + 10);
        cyc(3 * NO + 6);
        chk("R5 flag cleared after clean window", ovl_flag, 1'b0);

        // R9: disable during off span
        cur_req = "R9"; ovl_cmp = 1'b1;
        wait_out(1'b0, 50);
        chan_en = 1'b0; ovl_cmp = 1'b0; cyc(5);
        chk("R9 flag held while disabled", ovl_flag, 1'b1);
        chk("R9 output off while disabled", out_en, 1'b0);
        chan_en = 1'b1; cyc(1);
        chk("R9 off span abandoned", out_en, 1'b1);
        chk("R9 no limiting", ilim_active, 1'b0);

        // R6: static mode
        cur_req = "R6"; static_mode = 1'b1; ovl_cmp = 1'b1; cyc(60);
        chk("R6 output never shut", out_en, 1'b1);
        chk("R6 flag follows", ovl_flag, 1'b1);
        chk("R6 limiting", ilim_active, 1'b1);
        ovl_cmp = 1'b0; cyc(1);
        chk("R6 flag drops", ovl_flag, 1'b0);

        // R10: static to dynamic with overload present
        cur_req = "R10"; ovl_cmp = 1'b1; cyc(20);
        static_mode = 1'b0;
        cyc(3 * QO - 3);
        chk("R10 qualification restarted", out_en, 1'b1);
        wait_out(1'b0, 50);
        chk("R10 eventual trip", ovl_flag, 1'b1);
        ovl_cmp = 1'b0;
        wait_out(1'b1, 3 * FO + 10);
        cyc(3 * NO + 6);

        // R7/R8: back current
        cur_req = "R7"; bkc_cmp = 1'b1;
        cyc(3 * QB - 3);
        chk("R7 no trip before qualification", out_en, 1'b1);
        wait_out(1'b0, 50);
        chk("R7 flag set", bkc_flag, 1'b1);
        cur_req = "R8"; wait_out(1'b1, 3 * FB + 10);
        chk("R8 flag held while present", bkc_flag, 1'b1);
        wait_out(1'b0, 3 * QB + 10);
        chk("R8 cycles again", out_en, 1'b0);
        bkc_cmp = 1'b0;
        wait_out(1'b1, 3 * FB + 10);
        cyc(2);
        chk("R8 flag clears", bkc_flag, 1'b0);

        // R11: both loops off together
        cur_req = "R11"; ovl_cmp = 1'b1; bkc_cmp = 1'b1;
        cyc(200); ovl_cmp = 1'b0; bkc_cmp = 1'b0;
        cyc(3 * (FO + NO) + 20);
        chk("R11 output restored", out_en, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule